// File: doc/BRIEF.md
# Scrolling Display Refresh Scanner

This block is the display-side read engine of a 64-column graphic segment driver. A line counter selects which of the 64 stored lines is currently on the panel. On every line-clock enable the scanner reads that line from the display RAM, one column byte at a time. It picks out the one bit that belongs to the line from each byte and builds a 64-bit segment vector, which it presents together with a display-enable qualifier.

A frame pulse reloads the line counter from a start-line value, so the top of the screen can begin at any stored line. This gives hardware vertical scrolling without moving any RAM data. The counter wraps through all 64 lines.

The RAM read port is shared with the host port. The scanner raises `rd_valid` with an address, and the arbiter grants it with `rd_ready` only when no host access is using the RAM. Back-pressure rules: the scanner keeps `rd_valid` asserted and `rd_addr` unchanged while `rd_ready` is low. A read is accepted only in a cycle where both signals are high, and its byte is returned on `rd_data` in the following cycle. If the 64 reads of a line are not all accepted before the next line or frame pulse, that partial fetch is dropped and the segment vector keeps the previous row. Control inputs and the segment outputs are plain signals.

Top module: `disp_scan_refresh`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `seg_o` is all zero, `seg_en` is 0 and `rd_valid` is 0. Reset sets the line counter to 0, so the first `line_en` after reset fetches line 1.
- R2: A clock edge with `frame` high loads `start_line` into the line counter and begins a fetch of that line. In the next cycle `rd_valid` is 1 and `rd_addr` equals {start_line[5:3], 6'd0}.
- R3: A clock edge with `line_en` high and `frame` low advances the line counter by 1, wrapping from 63 to 0, and begins a fetch of the new line. When `frame` and `line_en` are both high, `frame` wins.
- R4: A fetch of line n issues 64 reads. `rd_addr[8:6]` holds n/8 (the page) and `rd_addr[5:0]` holds the column, which counts 0, 1, ..., 63 in order and advances by one after each accepted read. The byte for an accepted read is sampled from `rd_data` in the next cycle.
- R5: After a completed fetch of line n, bit k of the segment row equals bit (n mod 8) of the byte at column k when `col_rev` was 0 at fetch start. When `col_rev` was 1, bit k comes from column 63-k.
- R6: The new row appears on `seg_o` on the second clock edge after the edge that accepts the column-63 read.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, and no line or frame pulse is given, `rd_valid` stays 1 and `rd_addr` keeps its value in the next cycle.
- R8: A fetch that has not had all 64 reads accepted when the next `line_en` or `frame` edge arrives is abandoned. `seg_o` keeps the previously committed row.
- R9: One cycle after `disp_on` is sampled low, `seg_o` is all zero and `seg_en` is 0, while the stored row is kept. Once `disp_on` is high again, the same row reappears one cycle later.
- R10: After the column-63 read is accepted, `rd_valid` stays 0 until the next line or frame pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Line-clock enable: advance to the next line and fetch it |
| frame | input | 1 | Frame pulse: load the start line and fetch it |
| start_line | input | 6 | First line shown at the top of the screen |
| disp_on | input | 1 | Display enable flag |
| col_rev | input | 1 | Column order select, sampled at fetch start |
| rd_valid | output | 1 | Scanner read request to the RAM arbiter |
| rd_ready | input | 1 | Grant from the arbiter (low while the host uses the RAM) |
| rd_addr | output | 9 | Read address {page[2:0], column[5:0]} |
| rd_data | input | 8 | Byte returned one cycle after an accepted read |
| seg_o | output | 64 | Segment data vector, zero when the display is off |
| seg_en | output | 1 | Display-enable qualifier for `seg_o` |

## Verification
The bench targets the scroll boundary where the counter wraps from line 63 to 0. A design that saturated or skipped at the wrap would show rows from the wrong page. The bench also covers coincident frame and line pulses, where a design with the wrong priority would display the line after the start line.

Arbitration stalls and fully starved line periods are driven on purpose. A scanner that dropped its address under a stall, or committed a partially fetched row, would show corrupted or mixed segments instead of holding the old row. Reversed column order and the exact commit cycle are probed directly, so mirrored bits or an extra pipeline stage show up as miscompares. Toggling the display flag without a new line confirms that blanking does not destroy the stored row.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_ISSUE = 1'b1
  } fetch_state_t;

endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
  parameter int NUM_LINES = 64,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame,
  input  logic              line_en,
  input  logic [LINE_W-1:0] start_line,
  output logic [LINE_W-1:0] line_q
);

  localparam logic [LINE_W-1:0] TOP_LINE = LINE_W'(NUM_LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (frame) begin
      line_q <= start_line;
    end else if (line_en) begin
      line_q <= (line_q == TOP_LINE) ? '0 : line_q + 1'b1;
    end
  end

endmodule

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq
  import scan_pkg::*;
#(
  parameter int NUM_COLS = 64,
  parameter int PAGE_W   = 3,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PAGE_W-1:0]       page,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [PAGE_W+COL_W-1:0] rd_addr,
  output logic                    cap_v,
  output logic [COL_W-1:0]        cap_col,
  output logic                    row_done
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  fetch_state_t     st_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] cap_col_q;
  logic             cap_q;
  logic             done_q;
  logic             accept;

  assign accept = (st_q == FS_ISSUE) && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      col_q     <= '0;
      cap_col_q <= '0;
      cap_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= cap_q && (cap_col_q == LAST_COL) && !start;
      if (start) begin
        st_q  <= FS_ISSUE;
        col_q <= '0;
        cap_q <= 1'b0;
      end else begin
        cap_q <= accept;
        if (accept) begin
          cap_col_q <= col_q;
          if (col_q == LAST_COL) begin
            st_q <= FS_IDLE;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
      end
    end
  end

  assign rd_valid = (st_q == FS_ISSUE);
  assign rd_addr  = {page, col_q};
  assign cap_v    = cap_q;
  assign cap_col  = cap_col_q;
  assign row_done = done_q;

endmodule

// File: rtl/scan_row_asm.sv
module scan_row_asm #(
  parameter int NUM_COLS = 64,
  parameter int BYTE_W   = 8,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                col_rev,
  input  logic [BIT_W-1:0]    bit_sel,
  input  logic                cap_v,
  input  logic [COL_W-1:0]    cap_col,
  input  logic [BYTE_W-1:0]   rd_data,
  input  logic                row_done,
  output logic [NUM_COLS-1:0] row_q
);

  logic                rev_q;
  logic                pick;
  logic [NUM_COLS-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
    end else if (start) begin
      rev_q <= col_rev;
    end
  end

  assign pick = rd_data[bit_sel];

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_seg
    localparam logic [COL_W-1:0] FWD_COL = COL_W'(k);
    localparam logic [COL_W-1:0] REV_COL = COL_W'(NUM_COLS - 1 - k);
    logic hit;
    assign hit = cap_v && (cap_col == (rev_q ? REV_COL : FWD_COL));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[k] <= 1'b0;
      end else if (hit) begin
        shadow_q[k] <= pick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_done) begin
      row_q <= shadow_q;
    end
  end

endmodule

// File: rtl/disp_scan_refresh.sv
module disp_scan_refresh #(
  parameter int NUM_COLS  = 64,
  parameter int NUM_LINES = 64,
  parameter int BYTE_W    = 8,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int PAGE_W = LINE_W - BIT_W,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_en,
  input  logic                frame,
  input  logic [LINE_W-1:0]   start_line,
  input  logic                disp_on,
  input  logic                col_rev,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic [NUM_COLS-1:0] seg_o,
  output logic                seg_en
);

  logic [LINE_W-1:0]   line_q;
  logic                start;
  logic                cap_v;
  logic [COL_W-1:0]    cap_col;
  logic                row_done;
  logic [NUM_COLS-1:0] row_q;
  logic                disp_q;

  assign start = frame | line_en;

  scan_line_ctr #(.NUM_LINES(NUM_LINES)) u_line (
    .clk(clk), .rst_n(rst_n), .frame(frame), .line_en(line_en),
    .start_line(start_line), .line_q(line_q)
  );

  scan_fetch_seq #(.NUM_COLS(NUM_COLS), .PAGE_W(PAGE_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start),
    .page(line_q[LINE_W-1:BIT_W]),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .cap_v(cap_v), .cap_col(cap_col), .row_done(row_done)
  );

  scan_row_asm #(.NUM_COLS(NUM_COLS), .BYTE_W(BYTE_W)) u_row (
    .clk(clk), .rst_n(rst_n), .start(start), .col_rev(col_rev),
    .bit_sel(line_q[BIT_W-1:0]), .cap_v(cap_v), .cap_col(cap_col),
    .rd_data(rd_data), .row_done(row_done), .row_q(row_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_q <= 1'b0;
    end else begin
      disp_q <= disp_on;
    end
  end

  assign seg_o  = disp_q ? row_q : '0;
  assign seg_en = disp_q;

endmodule

// File: rtl/disp_scan_refresh_chk.sv
module disp_scan_refresh_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_en,
  input logic        frame,
  input logic [5:0]  start_line,
  input logic        disp_on,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [8:0]  rd_addr,
  input logic [63:0] seg_o,
  input logic        seg_en
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (seg_o == '0 && !seg_en && !rd_valid));

  // R2
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> (rd_valid && rd_addr[8:6] == $past(start_line[5:3]) && rd_addr[5:0] == 6'd0));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_addr[5:0] != 6'd63 && !line_en && !frame)
      |=> (rd_valid && rd_addr[5:0] == $past(rd_addr[5:0]) + 6'd1));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !line_en && !frame) |=> (rd_valid && $stable(rd_addr)));

  // R9
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_on) |-> (seg_o == '0 && !seg_en));

  // R10
  fetch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_addr[5:0] == 6'd63 && !line_en && !frame) |=> !rd_valid);

endmodule

bind disp_scan_refresh disp_scan_refresh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .frame(frame),
  .start_line(start_line), .disp_on(disp_on), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .seg_o(seg_o), .seg_en(seg_en)
);

// File: tb/disp_scan_refresh_tb.sv
`timescale 1ns/1ps
module disp_scan_refresh_tb;

  localparam int PERIOD = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_en = 1'b0;
  logic        frame = 1'b0;
  logic [5:0]  start_line = '0;
  logic        disp_on = 1'b0;
  logic        col_rev = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [8:0]  rd_addr;
  logic [7:0]  rd_data = '0;
  logic [63:0] seg_o;
  logic        seg_en;

  logic [7:0]  mem [0:7][0:63];
  logic [5:0]  exp_line = '0;
  logic [63:0] exp_row = '0;
  bit          exp_disp = 1'b0;
  int          vectors = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  disp_scan_refresh u_dut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .frame(frame),
    .start_line(start_line), .disp_on(disp_on), .col_rev(col_rev),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .seg_o(seg_o), .seg_en(seg_en)
  );

  always @(posedge clk) begin
    if (rd_valid && rd_ready) rd_data <= mem[rd_addr[8:6]][rd_addr[5:0]];
  end

  function automatic logic [63:0] row_of(input logic [5:0] ln, input bit rev);
    logic [63:0] r;
    for (int k = 0; k < 64; k++) begin
      r[k] = mem[ln[5:3]][rev ? 63 - k : k][ln[2:0]];
    end
    return r;
  endfunction

  function automatic logic [63:0] shown(input logic [63:0] r);
    return exp_disp ? r : 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic run_line(input bit fr, input bit le, input logic [5:0] st,
                          input bit rev, input int pct, input bit probe);
    int          hs;
    bit          addr_ok;
    bit          pstall;
    logic [8:0]  paddr;
    logic [63:0] nrow;
    @(negedge clk);
    frame = fr; line_en = le; start_line = st; col_rev = rev; rd_ready = 1'b0;
    if (fr) exp_line = st;
    else if (le) exp_line = exp_line + 6'd1;
    nrow = row_of(exp_line, rev);
    hs = 0; addr_ok = 1'b1; pstall = 1'b0; paddr = '0;
    for (int i = 1; i < PERIOD; i++) begin
      @(negedge clk);
      frame = 1'b0; line_en = 1'b0;
      rd_ready = (i < PERIOD - 5) && (($urandom % 100) < pct);
      if (pstall && rd_addr !== paddr) addr_ok = 1'b0;
      if (rd_valid && rd_ready) begin
        if (rd_addr !== {exp_line[5:3], 6'(hs)}) addr_ok = 1'b0;
        hs++;
      end
      pstall = rd_valid && !rd_ready;
      paddr  = rd_addr;
      if (probe && i == 66) check("R6 row not yet committed", seg_o, shown(exp_row));
      if (probe && i == 67) check("R6 row committed", seg_o, shown(nrow));
    end
    rd_ready = 1'b0;
    check("R4/R7 read address sequence and stall hold", {63'd0, addr_ok}, 64'd1);
    if (hs == 64) begin
      exp_row = nrow;
      check("R5 segment row", seg_o, shown(exp_row));
      check("R10 request idle after fetch", {63'd0, rd_valid}, 64'd0);
    end else begin
      check("R8 partial fetch holds old row", seg_o, shown(exp_row));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 64; c++)
        mem[p][c] = 8'($urandom);

    repeat (3) @(negedge clk);
    check("R1 seg_o in reset", seg_o, 64'd0);
    check("R1 seg_en in reset", {63'd0, seg_en}, 64'd0);
    check("R1 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    rst_n = 1'b1;
    disp_on = 1'b1;
    @(negedge clk);
    check("R1 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
    exp_disp = 1'b1;

    // R1: counter starts at 0, first line pulse fetches line 1
    run_line(1'b0, 1'b1, 6'd0, 1'b0, 100, 1'b1);
    // R2: frame load with scroll near the top of RAM
    run_line(1'b1, 1'b0, 6'd62, 1'b0, 100, 1'b1);
    // R3: 62 -> 63 -> 0 wrap
    run_line(1'b0, 1'b1, 6'd0, 1'b0, 100, 1'b0);
    run_line(1'b0, 1'b1, 6'd0, 1'b0, 100, 1'b0);
    // R5: reversed column order
    run_line(1'b0, 1'b1, 6'd0, 1'b1, 100, 1'b1);
    // R7/R8: host holds the RAM for a whole line
    run_line(1'b0, 1'b1, 6'd0, 1'b0, 0, 1'b0);
    // R3: frame and line pulse together, frame wins
    run_line(1'b1, 1'b1, 6'd10, 1'b0, 100, 1'b0);

    // R9: blank without losing the row, then restore
    @(negedge clk);
    disp_on = 1'b0;
    @(negedge clk);
    exp_disp = 1'b0;
    check("R9 blank segments", seg_o, 64'd0);
    check("R9 qualifier low", {63'd0, seg_en}, 64'd0);
    disp_on = 1'b1;
    @(negedge clk);
    exp_disp = 1'b1;
    check("R9 row restored", seg_o, exp_row);
    check("R9 qualifier high", {63'd0, seg_en}, 64'd1);

    // R7: stalled reads under partial grant
    run_line(1'b0, 1'b1, 6'd0, 1'b0, 60, 1'b0);

    for (int n = 0; n < 24; n++) begin
      bit fr;
      fr = (($urandom % 4) == 0);
      run_line(fr, !fr, 6'($urandom), 1'($urandom), 40 + int'($urandom % 61), 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule